// File: doc/BRIEF.md
# Weighted Bit-Flip Fault Injector

This block produces bit-flip masks that stand in for single-event upsets when several state registers of different widths are tested side by side. A down-counter fires an upset strobe once per programmable number of clocks. A free-running pseudo-random sequence picks one of 16 bit slots each time the strobe fires. Each target register owns a contiguous run of slots whose length equals its width, so a wider register is hit proportionally more often.

The single flipped bit is delivered either on the next-state path (XORed into the register's input, pre-register) or on the register output (post-register), as chosen by a mode input. The fault-free reference machine has its own mask port, which never carries a flip. An enable input gates all injection.

Top module: `fault_mask_gen`

## Requirements
- R1: While reset is held the period counter loads P-1, where P is the effective period. After reset is released, `fault_strobe` goes high for one cycle after P-1 rising edges, and then once every P cycles.
- R2: A `period` value of 0 selects the default period of 199 clocks.
- R3: At reset the 16-bit generator loads 0xACE1. On every clock after that it shifts left by one place, and bit 0 takes the XOR of bits 15, 14, 12 and 3. The generator also advances while injection is disabled. The slot number is the generator's low 4 bits in the strobe cycle.
- R4: In a strobe cycle exactly one mask bit is set, at the bit index equal to the slot. In every other cycle both masks are zero.
- R5: With `async_sel`=0 the flip appears on `sync_mask` and `async_mask` is zero. With `async_sel`=1 the flip appears on `async_mask` and `sync_mask` is zero.
- R6: With `inj_en`=0, `fault_strobe`, both masks and `tgt_hit` are zero. The counter and the generator keep running.
- R7: Slots 0-1 belong to target 0, slots 2-4 to target 1, slots 5-9 to target 2 and slots 10-15 to target 3. In a strobe cycle `tgt_hit` is one-hot on the owning target (bit k = target k). Over many strobes each target's share of the hits approaches its width divided by 16.
- R8: `ref_mask` is zero in every cycle.
- R9: A change to `period` during operation takes effect at the counter's next reload. The interval that is already running finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inj_en | input | 1 | Injection enable |
| async_sel | input | 1 | 0 = flip before the register, 1 = flip after the register |
| period | input | 16 | Clocks per upset; 0 selects 199 |
| fault_strobe | output | 1 | One-cycle marker of an injected upset |
| sync_mask | output | 16 | Flip mask for the next-state paths, targets packed from bit 0 |
| async_mask | output | 16 | Flip mask for the register outputs, same packing |
| tgt_hit | output | 4 | One-hot owner of the flipped slot |
| ref_mask | output | 4 | Mask for the reference machine, always zero |

## Verification
The bench keeps its own counter and sequence model, and compares every output on every cycle. The corner cases are a period of 1, where a design that reloads wrongly would skip strobes; a period of 0, where a design without the default would stall or wrap to 65535; and a period change in the middle of an interval, where an eager design would cut the running interval short. It also checks that turning injection off leaves the sequence advancing, so a design that froze the generator would shift every later slot. The boundary slots 1/2, 4/5 and 9/10 are checked against the range map, because an off-by-one there hands a flip to the wrong register. A long run confirms that each target's hit count follows its width.

// File: rtl/fault_mask_gen.sv
module fault_mask_gen #(
  parameter int          PW         = 16,
  parameter int          DEF_PERIOD = 199,
  parameter int          W0         = 2,
  parameter int          W1         = 3,
  parameter int          W2         = 5,
  parameter int          W3         = 6,
  parameter int          REF_W      = 4,
  parameter logic [15:0] SEED       = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inj_en,
  input  logic          async_sel,
  input  logic [PW-1:0] period,
  output logic          fault_strobe,
  output logic [15:0]   sync_mask,
  output logic [15:0]   async_mask,
  output logic [3:0]    tgt_hit,
  output logic [REF_W-1:0] ref_mask
);
  localparam int SLOTS = 16;
  localparam int NT    = 4;
  localparam int LO [0:NT] = '{0, W0, W0 + W1, W0 + W1 + W2, SLOTS};

  logic [PW-1:0]    eff, reload, cnt;
  logic [15:0]      lfsr;
  logic             fire;
  logic [3:0]       slot;
  logic [SLOTS-1:0] mask;

  assign eff    = (period == '0) ? PW'(DEF_PERIOD) : period;
  assign reload = eff - PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= reload;
      lfsr <= SEED;
    end else begin
      cnt  <= (cnt == '0) ? reload : cnt - PW'(1);
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3]};
    end
  end

  assign fire         = inj_en && (cnt == '0);
  assign slot         = lfsr[3:0];
  assign mask         = fire ? (SLOTS'(1) << slot) : '0;
  assign sync_mask    = async_sel ? '0 : mask;
  assign async_mask   = async_sel ? mask : '0;
  assign fault_strobe = fire;
  assign ref_mask     = '0;

  for (genvar k = 0; k < NT; k++) begin : g_tgt
    assign tgt_hit[k] = fire && (int'(slot) >= LO[k]) && (int'(slot) < LO[k+1]);
  end

  assert_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> (cnt == $past(reload)));
  assert_lfsr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lfsr[15:1] == $past(lfsr[14:0])));
  assert_lfsr_alive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);
  assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sync_mask | async_mask) == (fault_strobe ? 1 : 0));
  assert_route_R5: assert property (@(posedge clk) disable iff (!rst_n)
    async_sel |-> (sync_mask == '0));
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |-> (sync_mask == '0 && async_mask == '0 && tgt_hit == '0));
  assert_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_hit) && ((tgt_hit != '0) == fault_strobe));
endmodule

// File: tb/fault_mask_gen_tb.sv
`timescale 1ns/1ps
module fault_mask_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inj_en = 1'b0;
  logic        async_sel = 1'b0;
  logic [15:0] period = 16'd5;
  logic        fault_strobe;
  logic [15:0] sync_mask, async_mask;
  logic [3:0]  tgt_hit;
  logic [3:0]  ref_mask;

  int checks = 0;
  int errors = 0;
  int m_cnt;
  logic [15:0] m_l;
  int hits [4];
  int strobes;

  localparam int NV = 5;
  localparam int VP [NV] = '{5, 1, 0, 3, 2};
  localparam int VA [NV] = '{0, 1, 0, 1, 0};
  localparam int VE [NV] = '{1, 1, 1, 0, 1};
  localparam int VN [NV] = '{300, 60, 700, 120, 20000};
  localparam int WID [4] = '{2, 3, 5, 6};

  fault_mask_gen u_dut (
    .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .async_sel(async_sel),
    .period(period), .fault_strobe(fault_strobe), .sync_mask(sync_mask),
    .async_mask(async_mask), .tgt_hit(tgt_hit), .ref_mask(ref_mask)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [15:0] p);
    return (p == 16'd0) ? 199 : int'(p);
  endfunction

  function automatic logic [3:0] owner(input logic [3:0] s);
    if (s < 4'd2) return 4'b0001;
    if (s < 4'd5) return 4'b0010;
    if (s < 4'd10) return 4'b0100;
    return 4'b1000;
  endfunction

  task automatic compare_cycle();
    logic        ef;
    logic [15:0] em;
    logic [3:0]  et;
    ef = inj_en && (m_cnt == 0);
    em = ef ? (16'd1 << m_l[3:0]) : 16'd0;
    et = ef ? owner(m_l[3:0]) : 4'd0;
    chk(fault_strobe == ef, "R1/R2/R6/R9 strobe", 32'(fault_strobe), 32'(ef));
    chk(sync_mask == (async_sel ? 16'd0 : em), "R3/R4/R5 sync_mask", 32'(sync_mask), 32'(async_sel ? 16'd0 : em));
    chk(async_mask == (async_sel ? em : 16'd0), "R4/R5 async_mask", 32'(async_mask), 32'(async_sel ? em : 16'd0));
    chk(tgt_hit == et, "R7 tgt_hit", 32'(tgt_hit), 32'(et));
    chk(ref_mask == 4'd0, "R8 ref_mask", 32'(ref_mask), 32'd0);
    if (ef) begin
      strobes++;
      for (int k = 0; k < 4; k++) if (tgt_hit[k]) hits[k]++;
    end
  endtask

  task automatic model_step();
    m_cnt = (m_cnt == 0) ? eff(period) - 1 : m_cnt - 1;
    m_l = {m_l[14:0], m_l[15] ^ m_l[14] ^ m_l[12] ^ m_l[3]};
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      compare_cycle();
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic do_reset(input int p, input bit a, input bit e);
    @(negedge clk);
    rst_n = 1'b0; period = 16'(p); async_sel = a; inj_en = e;
    @(posedge clk); @(posedge clk); @(negedge clk);
    m_cnt = eff(period) - 1;
    m_l = 16'hACE1;
    strobes = 0;
    for (int k = 0; k < 4; k++) hits[k] = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state: period 5, counter at 4, no strobe, masks clear
    do_reset(5, 0, 1);
    chk(fault_strobe == 1'b0, "R1 reset strobe", 32'(fault_strobe), 32'd0);
    chk(sync_mask == 16'd0 && async_mask == 16'd0, "R4 reset masks", 32'(sync_mask | async_mask), 32'd0);

    for (int v = 0; v < NV; v++) begin
      do_reset(VP[v], VA[v][0], VE[v][0]);
      run_cycles(VN[v]);
      if (v == NV - 1) begin
        for (int k = 0; k < 4; k++) begin
          int lo, hi;
          lo = (WID[k] * strobes * 8) / 160;
          hi = (WID[k] * strobes * 12) / 160;
          chk(hits[k] >= lo && hits[k] <= hi, "R7 share", 32'(hits[k]), 32'((WID[k] * strobes) / 16));
        end
      end
    end

    // R9: change period mid-interval, running interval completes first
    do_reset(10, 0, 1);
    run_cycles(4);
    period = 16'd3;
    run_cycles(30);

    // R6: disable then re-enable; generator must keep advancing
    do_reset(4, 1, 1);
    run_cycles(20);
    inj_en = 1'b0;
    run_cycles(37);
    inj_en = 1'b1;
    run_cycles(40);

    // R2: period 0 gives first strobe after 198 edges
    do_reset(0, 0, 1);
    run_cycles(198);
    chk(fault_strobe == 1'b1, "R2 default period strobe", 32'(fault_strobe), 32'd1);
    run_cycles(210);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule